// File: doc/BRIEF.md
# Mailbox transmit request and cancel controller

This block keeps, for each of fifteen transmit-capable mailboxes of a CAN controller, a transmit-pending flag, a cancel flag, a transmit-acknowledge flag and an abort-acknowledge flag. Mailbox 0 receives only. Its position in every vector is fixed at zero. A CPU sets and reads these vectors through a small register port. When mailboxes are pending and the bit engine is idle, the block picks one and sends a start pulse with the mailbox number. It then waits for the engine to report success or failure.

A cancel removes a queued mailbox from the queue and acknowledges the abort. A cancel cannot stop a frame that is already on the bus. Such a frame ends with a transmit acknowledge if it succeeds, or with an abort acknowledge if it fails. A failed frame that was not cancelled stays queued and competes again. A configuration input selects the queue order. In identifier order the lowest message identifier goes first. In number order the highest mailbox number goes first.

Top module: `mbx_tx_ctrl`

## Requirements
- R1: Bit 0 of the pending vector (address 0) and of the cancel vector (address 1) always reads 0. Writing 1 there starts nothing.
- R2: Writing 1 to a bit at address 0 sets that mailbox's pending flag. Writing 0 leaves the flag unchanged.
- R3: Writing 1 to a bit at address 1 sets the cancel flag only if that mailbox is pending. Otherwise the write is ignored and no acknowledge appears.
- R4: A cancel of a pending mailbox that is not in flight clears its pending and cancel flags within two cycles. It also sets its abort-acknowledge flag (address 3).
- R5: A cancel of the in-flight mailbox leaves its cancel flag readable until the frame ends. If the frame succeeds, the pending and cancel flags clear and the transmit-acknowledge flag (address 2) sets.
- R6: If an in-flight frame with its cancel flag set fails, its pending and cancel flags clear and its abort-acknowledge flag sets.
- R7: A successful frame clears the mailbox's pending flag and sets its transmit-acknowledge flag.
- R8: A failed frame without a cancel keeps its pending flag and is started again.
- R9: When prio_by_id is 1, the pending non-cancelled mailbox with the lowest identifier starts first. An identifier tie goes to the higher mailbox number.
- R10: When prio_by_id is 0, the highest-numbered pending non-cancelled mailbox starts first.
- R11: The acknowledge vectors clear bits written as 1, and writing 0 leaves a bit unchanged. A hardware set in the same cycle as a clear of the same bit leaves the bit set.
- R12: At most one frame is in flight. tx_start pulses for one cycle with tx_mbx between 1 and 15. No further start comes before that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 pending, 1 cancel, 2 transmit ack, 3 abort ack |
| reg_wdata | input | 16 | Write data, one bit per mailbox |
| reg_rdata | output | 16 | Read data of the addressed vector |
| prio_by_id | input | 1 | 1 selects identifier order, 0 selects number order |
| mbx_ids | input | 16*ID_W | Message identifier of each mailbox, mailbox i at bits i*ID_W upward |
| tx_start | output | 1 | One-cycle start request to the bit engine |
| tx_mbx | output | 4 | Mailbox in flight |
| eng_ok | input | 1 | Engine reports success of the frame in flight |
| eng_fail | input | 1 | Engine reports arbitration loss or bus error |

## Verification
The bench queues every transmit mailbox at once and checks the full start order in number mode. It then checks the order in identifier mode under two identifier patterns, one of them with ties. A design with reversed priority or a wrong tie-break would send a different mailbox at some position. Cancels are tried on an idle mailbox, on a queued mailbox and on the mailbox in flight under both outcomes. A design that aborted an in-flight frame, or accepted a cancel for an idle mailbox, would show the wrong acknowledge vector. The bench also checks that a failed frame is retried. It also drives a clear of an acknowledge bit in the same cycle as the hardware set of that bit, which shows whether the clear wrongly wins.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;
    localparam int MBX_N = 16;
    localparam int MBX_W = $clog2(MBX_N);
    localparam logic [MBX_N-1:0] TX_MASK = {{(MBX_N-1){1'b1}}, 1'b0};

    typedef enum logic [1:0] {
        A_PEND  = 2'd0,
        A_CANC  = 2'd1,
        A_TXACK = 2'd2,
        A_ABACK = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [MBX_N-1:0] pend;
        logic [MBX_N-1:0] canc;
        logic [MBX_N-1:0] txack;
        logic [MBX_N-1:0] aback;
        logic             busy;
        logic [MBX_W-1:0] cur;
        logic             start;
    } tx_state_t;
endpackage

// File: rtl/mbx_pick_num.sv
module mbx_pick_num
    import mbx_tx_pkg::*;
(
    input  logic [MBX_N-1:0] elig,
    output logic [MBX_W-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int i = 1; i < MBX_N; i++) begin
            if (elig[i]) sel = i[MBX_W-1:0];
        end
    end
endmodule

// File: rtl/mbx_pick_id.sv
module mbx_pick_id
    import mbx_tx_pkg::*;
#(
    parameter int ID_W = 11
) (
    input  logic [MBX_N-1:0]      elig,
    input  logic [MBX_N*ID_W-1:0] ids,
    output logic [MBX_W-1:0]      sel
);
    logic [ID_W-1:0] best_id;
    logic            found;

    always_comb begin
        sel     = '0;
        best_id = '1;
        found   = 1'b0;
        for (int i = 1; i < MBX_N; i++) begin
            if (elig[i] && (!found || ids[i*ID_W +: ID_W] <= best_id)) begin
                found   = 1'b1;
                sel     = i[MBX_W-1:0];
                best_id = ids[i*ID_W +: ID_W];
            end
        end
    end
endmodule

// File: rtl/mbx_tx_ctrl.sv
module mbx_tx_ctrl
    import mbx_tx_pkg::*;
#(
    parameter int ID_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [15:0]           reg_wdata,
    output logic [15:0]           reg_rdata,
    input  logic                  prio_by_id,
    input  logic [16*ID_W-1:0]    mbx_ids,
    output logic                  tx_start,
    output logic [3:0]            tx_mbx,
    input  logic                  eng_ok,
    input  logic                  eng_fail
);
    tx_state_t        st_d, st_q;
    logic [MBX_N-1:0] elig;
    logic [MBX_W-1:0] sel_num, sel_id, sel;
    logic [MBX_N-1:0] wbits;
    logic [MBX_N-1:0] hw_tx, hw_ab;

    assign elig = st_q.pend & ~st_q.canc & TX_MASK;

    mbx_pick_num u_pick_num (
        .elig (elig),
        .sel  (sel_num)
    );

    mbx_pick_id #(.ID_W(ID_W)) u_pick_id (
        .elig (elig),
        .ids  (mbx_ids),
        .sel  (sel_id)
    );

    assign sel   = prio_by_id ? sel_id : sel_num;
    assign wbits = reg_wdata & TX_MASK;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        hw_tx      = '0;
        hw_ab      = '0;

        // end of the frame in flight
        if (st_q.busy && (eng_ok || eng_fail)) begin
            st_d.busy = 1'b0;
            if (eng_ok) begin
                st_d.pend[st_q.cur] = 1'b0;
                st_d.canc[st_q.cur] = 1'b0;
                hw_tx[st_q.cur]     = 1'b1;
            end else if (st_q.canc[st_q.cur]) begin
                st_d.pend[st_q.cur] = 1'b0;
                st_d.canc[st_q.cur] = 1'b0;
                hw_ab[st_q.cur]     = 1'b1;
            end
        end

        // queued cancels take effect
        for (int i = 1; i < MBX_N; i++) begin
            if (st_q.canc[i] && !(st_q.busy && st_q.cur == i[MBX_W-1:0])) begin
                st_d.pend[i] = 1'b0;
                st_d.canc[i] = 1'b0;
                hw_ab[i]     = 1'b1;
            end
        end

        // CPU writes
        st_d.txack = st_q.txack;
        st_d.aback = st_q.aback;
        if (reg_wr) begin
            unique case (reg_addr_e'(reg_addr))
                A_PEND:  st_d.pend  = st_d.pend | wbits;
                A_CANC:  st_d.canc  = st_d.canc | (wbits & st_d.pend);
                A_TXACK: st_d.txack = st_q.txack & ~wbits;
                A_ABACK: st_d.aback = st_q.aback & ~wbits;
                default: ;
            endcase
        end
        st_d.txack = (st_d.txack | hw_tx) & TX_MASK;
        st_d.aback = (st_d.aback | hw_ab) & TX_MASK;

        // launch the next frame
        if (!st_q.busy && (|elig)) begin
            st_d.busy  = 1'b1;
            st_d.cur   = sel;
            st_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            A_PEND:  reg_rdata = st_q.pend;
            A_CANC:  reg_rdata = st_q.canc;
            A_TXACK: reg_rdata = st_q.txack;
            A_ABACK: reg_rdata = st_q.aback;
            default: reg_rdata = '0;
        endcase
    end

    assign tx_start = st_q.start;
    assign tx_mbx   = st_q.cur;
endmodule

// File: rtl/mbx_tx_ctrl_chk.sv
module mbx_tx_ctrl_chk
    import mbx_tx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [MBX_N-1:0] pend,
    input logic [MBX_N-1:0] canc,
    input logic [MBX_N-1:0] txack,
    input logic [MBX_N-1:0] aback,
    input logic             busy,
    input logic [MBX_W-1:0] cur,
    input logic             start,
    input logic             eng_ok,
    input logic             eng_fail
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0] && !canc[0] && !txack[0] && !aback[0]);

    // R3
    cancel_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (canc & ~pend) == '0);

    // R12
    start_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (busy && cur != '0 && pend[cur]));

    // R12
    flight_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_ok && !eng_fail) |=> (busy && !start && $stable(cur)));

    // R5
    ok_sets_txack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_ok) |=> (txack[$past(cur)] && !pend[$past(cur)]));

    // R6
    fail_cancel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_ok && eng_fail && canc[cur]) |=> (aback[$past(cur)] && !pend[$past(cur)]));

    // R8
    fail_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_ok && eng_fail && !canc[cur]) |=> pend[$past(cur)]);
endmodule

bind mbx_tx_ctrl mbx_tx_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (st_q.pend),
    .canc     (st_q.canc),
    .txack    (st_q.txack),
    .aback    (st_q.aback),
    .busy     (st_q.busy),
    .cur      (st_q.cur),
    .start    (st_q.start),
    .eng_ok   (eng_ok),
    .eng_fail (eng_fail)
);

// File: tb/mbx_tx_ctrl_test.sv
module mbx_tx_ctrl_test;
    localparam int CLK_P = 10;
    localparam int ID_W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              prio_by_id = 1'b0;
    logic [16*ID_W-1:0] mbx_ids = '0;
    logic              tx_start;
    logic [3:0]        tx_mbx;
    logic              eng_ok = 1'b0;
    logic              eng_fail = 1'b0;

    int checks = 0;
    int fails = 0;
    int start_cnt = 0;
    int seen = 0;
    int last_mbx = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    mbx_tx_ctrl #(.ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prio_by_id(prio_by_id),
        .mbx_ids(mbx_ids), .tx_start(tx_start), .tx_mbx(tx_mbx),
        .eng_ok(eng_ok), .eng_fail(eng_fail)
    );

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (rst_n && tx_start) begin
            start_cnt = start_cnt + 1;
            last_mbx  = int'(tx_mbx);
        end
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_start(input string tag, output int m);
        int n = 0;
        while (start_cnt <= seen && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (start_cnt <= seen) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL %s: act=no start exp=start", tag);
            m = -1;
        end else begin
            seen = start_cnt;
            m = last_mbx;
        end
    endtask

    task automatic finish_frame(input bit ok);
        @(negedge clk);
        eng_ok = ok; eng_fail = !ok;
        @(negedge clk);
        eng_ok = 1'b0; eng_fail = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic order_run(input string tag);
        int ids[16];
        bit done[16];
        int m;
        for (int i = 0; i < 16; i++) begin
            ids[i]  = int'(mbx_ids[i*ID_W +: ID_W]);
            done[i] = 1'b0;
        end
        wr(2'd0, 16'hFFFE);
        for (int k = 0; k < 15; k++) begin
            int best = -1;
            for (int i = 1; i < 16; i++) begin
                if (!done[i]) begin
                    if (!prio_by_id) best = i;
                    else if (best < 0 || ids[i] <= ids[best]) best = i;
                end
            end
            done[best] = 1'b1;
            wait_start(tag, m);
            chk(tag, m, best);
            finish_frame(1'b1);
        end
        idle(3);
        rd_chk({tag, " R7 pend empty"}, 2'd0, 0);
        rd_chk({tag, " R7 txack all"}, 2'd2, 16'hFFFE);
        wr(2'd2, 16'hFFFE);
        rd_chk({tag, " R11 txack cleared"}, 2'd2, 0);
    endtask

    initial begin
        int m;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        rd_chk("reset pend", 2'd0, 0);
        rd_chk("reset canc", 2'd1, 0);
        rd_chk("reset txack", 2'd2, 0);
        rd_chk("reset aback", 2'd3, 0);
        chk("reset tx_start", int'(tx_start), 0);

        // R1 reserved bit
        wr(2'd0, 16'h0001);
        idle(4);
        rd_chk("R1 pend bit0", 2'd0, 0);
        chk("R1 no start", start_cnt, 0);
        wr(2'd1, 16'h0001);
        rd_chk("R1 canc bit0", 2'd1, 0);

        // R3 cancel of an idle mailbox
        wr(2'd1, 16'h0008);
        idle(2);
        rd_chk("R3 canc ignored", 2'd1, 0);
        rd_chk("R3 no abort ack", 2'd3, 0);

        // R10 number order
        prio_by_id = 1'b0;
        order_run("R10 order");

        // R9 identifier order, distinct and tied identifiers
        prio_by_id = 1'b1;
        for (int i = 0; i < 16; i++) mbx_ids[i*ID_W +: ID_W] = ID_W'((i * 7) % 16 + 20);
        order_run("R9 order distinct");
        for (int i = 0; i < 16; i++) mbx_ids[i*ID_W +: ID_W] = ID_W'((i * 5) % 4);
        order_run("R9 order ties");
        prio_by_id = 1'b0;

        // R2 and R4: mailbox 15 in flight, mailbox 5 queued
        wr(2'd0, 16'h8020);
        wait_start("R12 start 15", m);
        chk("R10 start 15", m, 15);
        idle(5);
        chk("R12 single flight", start_cnt, seen);
        wr(2'd0, 16'h0000);
        rd_chk("R2 write zero keeps", 2'd0, 16'h8020);
        wr(2'd1, 16'h0020);
        idle(2);
        rd_chk("R4 pend cleared", 2'd0, 16'h8000);
        rd_chk("R4 canc cleared", 2'd1, 0);
        rd_chk("R4 aback set", 2'd3, 16'h0020);
        wr(2'd3, 16'h0020);
        rd_chk("R11 aback cleared", 2'd3, 0);

        // R5 cancel in flight then success
        wr(2'd1, 16'h8000);
        idle(2);
        rd_chk("R5 canc held", 2'd1, 16'h8000);
        rd_chk("R5 pend held", 2'd0, 16'h8000);
        finish_frame(1'b1);
        idle(1);
        rd_chk("R5 txack", 2'd2, 16'h8000);
        rd_chk("R5 no aback", 2'd3, 0);
        rd_chk("R5 pend cleared", 2'd0, 0);
        rd_chk("R5 canc cleared", 2'd1, 0);
        wr(2'd2, 16'h8000);

        // R6 cancel in flight then failure
        wr(2'd0, 16'h0400);
        wait_start("R6 start", m);
        chk("R6 start 10", m, 10);
        wr(2'd1, 16'h0400);
        finish_frame(1'b0);
        idle(2);
        rd_chk("R6 aback", 2'd3, 16'h0400);
        rd_chk("R6 pend cleared", 2'd0, 0);
        rd_chk("R6 no txack", 2'd2, 0);
        chk("R6 no restart", start_cnt, seen);
        wr(2'd3, 16'h0400);

        // R8 failure without cancel retries
        wr(2'd0, 16'h0200);
        wait_start("R8 start", m);
        chk("R8 start 9", m, 9);
        finish_frame(1'b0);
        wait_start("R8 retry", m);
        chk("R8 retry 9", m, 9);
        rd_chk("R8 still pending", 2'd0, 16'h0200);
        finish_frame(1'b1);
        idle(1);
        rd_chk("R7 txack 9", 2'd2, 16'h0200);
        wr(2'd2, 16'h0200);

        // R11 hardware set wins over same-cycle clear
        wr(2'd0, 16'h0100);
        wait_start("R11 start", m);
        @(negedge clk);
        eng_ok = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0100;
        @(negedge clk);
        eng_ok = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd_chk("R11 set wins", 2'd2, 16'h0100);

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule